// File: doc/BRIEF.md
# Sector Buffer Write-Pointer Manager

This block runs the store side of a circular sector buffer inside an optical-disc data decoder. It holds two 16-bit pointers. The first is a write address that runs ahead of the stored data. The second is a current-sector pointer that marks where the sector now being stored begins.

A host reaches each pointer as a pair of byte registers. Through them it can load either byte and read either byte back.

Each time a new sector arrives, both pointers step forward by one sector length and wrap on a 15-bit mask. The block then copies the sector into the buffer, one byte per clock, starting at the stepped current-sector pointer. The copy takes one of two forms:
- In decoded form, the block first writes a four-byte header that it latched when the sector was accepted, and then the 2048 user bytes.
- In raw form, it writes all 2352 bytes of the sector exactly as they arrive.

The block fetches sector bytes from a source memory. It places a byte index on `src_addr` and expects the byte on `src_data` in the same cycle.

Top module: `sbuf_wr_ptr_mgr`

## Requirements
- R1: After a synchronous active-low reset, the write address reads 4704 (0x1260, twice the sector length) and the current-sector pointer reads 0. `busy`, `buf_we`, `sec_done` and `overrun` are all low.
- R2: Host register select codes are:
  - 0: write address bits 7:0
  - 1: write address bits 15:8
  - 2: current-sector pointer bits 7:0
  - 3: current-sector pointer bits 15:8

  When `reg_wr` is high, `reg_wdata` is loaded into the selected byte only, and the change is seen at the next edge. `reg_rdata` shows the selected byte combinationally.
- R3: On an accepted `sec_start` (one that arrives while `busy` is low), both pointers become (old value + 2352) AND 0x7FFF at the next edge. If a host load coincides with the acceptance, the step takes precedence.
- R4: Decoded sector (`sec_decoded` = 1 at acceptance). Let P be the stepped current-sector pointer. The block makes 2052 writes, to addresses P+0 through P+2051:
  - The first four writes carry the header bytes latched at acceptance: byte k is `hdr_in[8k+7:8k]`.
  - Write 4+j carries source byte j, for j from 0 to 2047.
- R5: Raw sector (`sec_decoded` = 0 at acceptance). The block makes 2352 writes, to addresses P+0 through P+2351. Write k carries source byte k.
- R6: Writes begin in the cycle after acceptance and continue one per clock with no gap. `busy` equals `buf_we`. `sec_done` is high in exactly the last write cycle, and `busy` is low in the following cycle.
- R7: A `sec_start` that arrives while `busy` is high is ignored. It does not change either pointer and does not disturb the stream in progress. It sets `overrun`, which stays high until reset.
- R8: `buf_addr` is the sum of P and the byte offset, taken modulo 2^16 and not masked. A host load during a sector changes the register but not the addresses of that sector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Host byte load strobe |
| reg_sel | input | 2 | Host register select |
| reg_wdata | input | 8 | Host load byte |
| reg_rdata | output | 8 | Selected register byte |
| sec_start | input | 1 | New sector available |
| sec_decoded | input | 1 | 1 = decoded form, 0 = raw form |
| hdr_in | input | 32 | Header bytes, byte 0 in the low bits |
| src_addr | output | 12 | Index of the sector byte wanted |
| src_data | input | 8 | Sector byte at `src_addr` |
| buf_we | output | 1 | Buffer write enable |
| buf_addr | output | 16 | Buffer write address |
| buf_wdata | output | 8 | Buffer write byte |
| busy | output | 1 | Sector copy in progress |
| sec_done | output | 1 | Last write of the sector |
| overrun | output | 1 | Sticky ignored-start flag |

## Verification
The bench preloads the current-sector pointer with values chosen to exercise the pointer step:
- values just below the 15-bit boundary, where the step must wrap;
- values with bit 15 set, where a design that wraps on a multiple of the sector length, or that forgets the mask, leaves the pointer at the wrong value;
- values that only cross a byte, where a design that loses a carry goes wrong.

Every byte of every sector is compared in both forms. A design that puts the header at the end, that shifts the user data, or that stops one byte early or late fails this comparison at a known offset.

A start pulse in the middle of a sector catches a design that restarts the stream or steps the pointers twice. A host load in the middle of a sector catches a design that follows the live register instead of the base it latched at acceptance.

// File: rtl/sbuf_pkg.sv
// Shared constants and the host register select encoding for the
// sector buffer write-pointer manager.
package sbuf_pkg;
    localparam int SBUF_SECTOR_BYTES = 2352;
    localparam int SBUF_DATA_BYTES   = 2048;
    localparam int SBUF_HDR_BYTES    = 4;
    localparam int SBUF_PTR_W        = 16;
    localparam int SBUF_WRAP_BITS    = 15;

    // Bit 1 picks the pointer (0 = write address, 1 = sector pointer),
    // bit 0 picks the byte (0 = low, 1 = high).
    typedef enum logic [1:0] {
        SEL_WA_LO = 2'd0,
        SEL_WA_HI = 2'd1,
        SEL_PT_LO = 2'd2,
        SEL_PT_HI = 2'd3
    } host_sel_e;
endpackage

// File: rtl/sbuf_ptr.sv
// One buffer pointer. The host loads it a byte at a time. An advance
// request steps it by STEP and masks the result to WRAP_BITS bits.
// Assumes PTR_W is between 9 and 16 and WRAP_BITS < PTR_W. An advance wins
// over a byte load in the same cycle.
module sbuf_ptr #(
    parameter int PTR_W     = 16,
    parameter int WRAP_BITS = 15,
    parameter int STEP      = 2352,
    parameter logic [PTR_W-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             ld_lo,
    input  logic             ld_hi,
    input  logic [7:0]       wbyte,
    output logic [PTR_W-1:0] q,
    output logic [PTR_W-1:0] q_step
);
    localparam logic [PTR_W-1:0] MASK = {{(PTR_W-WRAP_BITS){1'b0}}, {WRAP_BITS{1'b1}}};

    // Next value after one sector step, wrapped on the mask.
    always_comb q_step = (q + PTR_W'(STEP)) & MASK;

    // Pointer register: reset, step, or byte load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= RESET_VAL;
        end else if (adv) begin
            q <= q_step;
        end else begin
            if (ld_lo) q[7:0]       <= wbyte;
            if (ld_hi) q[PTR_W-1:8] <= wbyte[PTR_W-9:0];
        end
    end

    // R3
    mask_after_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> ((q & ~MASK) == '0));
endmodule

// File: rtl/sbuf_seq.sv
// Sector copy sequencer. It accepts a start when idle and latches the form,
// the header and the base address. It then counts byte offsets one per
// clock until the last byte of the chosen form. A start while busy is
// dropped and recorded in a sticky flag.
module sbuf_seq #(
    parameter int PTR_W        = 16,
    parameter int SECTOR_BYTES = 2352,
    parameter int DATA_BYTES   = 2048,
    parameter int HDR_BYTES    = 4,
    parameter int CNT_W        = $clog2(SECTOR_BYTES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sec_start,
    input  logic                   sec_decoded,
    input  logic [8*HDR_BYTES-1:0] hdr_in,
    input  logic [PTR_W-1:0]       base_in,
    output logic                   accept,
    output logic                   busy,
    output logic [CNT_W-1:0]       offs,
    output logic                   decoded_q,
    output logic [8*HDR_BYTES-1:0] hdr_q,
    output logic [PTR_W-1:0]       base_q,
    output logic                   sec_done,
    output logic                   overrun
);
    localparam logic [CNT_W-1:0] LAST_DEC = CNT_W'(HDR_BYTES + DATA_BYTES - 1);
    localparam logic [CNT_W-1:0] LAST_RAW = CNT_W'(SECTOR_BYTES - 1);

    logic last;

    // Acceptance and end-of-sector detection.
    always_comb begin
        accept   = sec_start && !busy;
        last     = (offs == (decoded_q ? LAST_DEC : LAST_RAW));
        sec_done = busy && last;
    end

    // Copy state: latch on acceptance, count while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            offs      <= '0;
            decoded_q <= 1'b0;
            hdr_q     <= '0;
            base_q    <= '0;
        end else if (accept) begin
            busy      <= 1'b1;
            offs      <= '0;
            decoded_q <= sec_decoded;
            hdr_q     <= hdr_in;
            base_q    <= base_in;
        end else if (busy) begin
            if (last) busy <= 1'b0;
            else      offs <= offs + 1'b1;
        end
    end

    // Sticky record of starts that arrived while busy.
    always_ff @(posedge clk) begin
        if (!rst_n)                  overrun <= 1'b0;
        else if (sec_start && busy)  overrun <= 1'b1;
    end

    // R6
    offset_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !last) |=> (busy && offs == $past(offs) + 1'b1));
    // R6
    done_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sec_done |=> !busy);
    // R7
    overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_start && busy) |=> overrun);
    // R7
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(overrun));
endmodule

// File: rtl/sbuf_wmux.sv
// Buffer write port. It forms the address from the latched base plus the
// offset, modulo 2^PTR_W. In decoded form it sends the header bytes first,
// then the source bytes. Assumes the source answers src_addr within the
// same cycle.
module sbuf_wmux #(
    parameter int PTR_W     = 16,
    parameter int HDR_BYTES = 4,
    parameter int CNT_W     = 12
) (
    input  logic                   busy,
    input  logic                   decoded_q,
    input  logic [CNT_W-1:0]       offs,
    input  logic [PTR_W-1:0]       base_q,
    input  logic [8*HDR_BYTES-1:0] hdr_q,
    input  logic [7:0]             src_data,
    output logic                   buf_we,
    output logic [PTR_W-1:0]       buf_addr,
    output logic [7:0]             buf_wdata,
    output logic [CNT_W-1:0]       src_addr
);
    localparam int HIDX_W = (HDR_BYTES > 1) ? $clog2(HDR_BYTES) : 1;

    logic              hdr_phase;
    logic [HIDX_W-1:0] hidx;

    // Select header or source byte and form the buffer address.
    always_comb begin
        hdr_phase = decoded_q && (offs < CNT_W'(HDR_BYTES));
        hidx      = offs[HIDX_W-1:0];
        buf_we    = busy;
        buf_addr  = base_q + PTR_W'(offs);
        src_addr  = hdr_phase ? '0 : (decoded_q ? offs - CNT_W'(HDR_BYTES) : offs);
        buf_wdata = hdr_phase ? hdr_q[8*int'(hidx) +: 8] : src_data;
    end
endmodule

// File: rtl/sbuf_wr_ptr_mgr.sv
// Top of the sector buffer write-pointer manager. It holds the write
// address (index 0) and the current-sector pointer (index 1), decodes host
// byte loads and readback, and joins the sequencer to the write port.
// Assumes a 16-bit pointer exposed as two host bytes.
module sbuf_wr_ptr_mgr
    import sbuf_pkg::*;
#(
    parameter int SECTOR_BYTES = SBUF_SECTOR_BYTES,
    parameter int DATA_BYTES   = SBUF_DATA_BYTES,
    parameter int HDR_BYTES    = SBUF_HDR_BYTES,
    parameter int WRAP_BITS    = SBUF_WRAP_BITS,
    localparam int PTR_W       = SBUF_PTR_W,
    localparam int CNT_W       = $clog2(SECTOR_BYTES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_wr,
    input  logic [1:0]             reg_sel,
    input  logic [7:0]             reg_wdata,
    output logic [7:0]             reg_rdata,
    input  logic                   sec_start,
    input  logic                   sec_decoded,
    input  logic [8*HDR_BYTES-1:0] hdr_in,
    output logic [CNT_W-1:0]       src_addr,
    input  logic [7:0]             src_data,
    output logic                   buf_we,
    output logic [PTR_W-1:0]       buf_addr,
    output logic [7:0]             buf_wdata,
    output logic                   busy,
    output logic                   sec_done,
    output logic                   overrun
);
    logic [PTR_W-1:0]       ptr_q    [2];
    logic [PTR_W-1:0]       ptr_step [2];
    logic                   accept;
    logic [CNT_W-1:0]       offs;
    logic                   decoded_q;
    logic [8*HDR_BYTES-1:0] hdr_q;
    logic [PTR_W-1:0]       base_q;

    // Two pointer instances: write address resets to two sectors, the
    // sector pointer to zero.
    for (genvar g = 0; g < 2; g++) begin : g_ptr
        localparam logic [PTR_W-1:0] RV = (g == 0) ? PTR_W'(2 * SECTOR_BYTES) : '0;
        logic ld_lo, ld_hi;

        // Host byte-load decode for this pointer.
        always_comb begin
            ld_lo = reg_wr && (reg_sel[1] == 1'(g)) && !reg_sel[0];
            ld_hi = reg_wr && (reg_sel[1] == 1'(g)) &&  reg_sel[0];
        end

        sbuf_ptr #(
            .PTR_W(PTR_W), .WRAP_BITS(WRAP_BITS), .STEP(SECTOR_BYTES), .RESET_VAL(RV)
        ) u_ptr (
            .clk(clk), .rst_n(rst_n), .adv(accept), .ld_lo(ld_lo), .ld_hi(ld_hi),
            .wbyte(reg_wdata), .q(ptr_q[g]), .q_step(ptr_step[g])
        );
    end

    // Host readback of the selected byte.
    always_comb begin
        reg_rdata = reg_sel[0] ? 8'(ptr_q[reg_sel[1]] >> 8) : ptr_q[reg_sel[1]][7:0];
    end

    sbuf_seq #(
        .PTR_W(PTR_W), .SECTOR_BYTES(SECTOR_BYTES), .DATA_BYTES(DATA_BYTES),
        .HDR_BYTES(HDR_BYTES), .CNT_W(CNT_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .sec_start(sec_start), .sec_decoded(sec_decoded),
        .hdr_in(hdr_in), .base_in(ptr_step[1]), .accept(accept), .busy(busy),
        .offs(offs), .decoded_q(decoded_q), .hdr_q(hdr_q), .base_q(base_q),
        .sec_done(sec_done), .overrun(overrun)
    );

    sbuf_wmux #(
        .PTR_W(PTR_W), .HDR_BYTES(HDR_BYTES), .CNT_W(CNT_W)
    ) u_wmux (
        .busy(busy), .decoded_q(decoded_q), .offs(offs), .base_q(base_q),
        .hdr_q(hdr_q), .src_data(src_data), .buf_we(buf_we), .buf_addr(buf_addr),
        .buf_wdata(buf_wdata), .src_addr(src_addr)
    );

    // R7
    ignored_start_pt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_start && busy && !reg_wr) |=> $stable(ptr_q[1]));
    // R7
    ignored_start_wa_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_start && busy && !reg_wr) |=> $stable(ptr_q[0]));
    // R8
    addr_hold_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !sec_done) |=> (buf_addr == $past(buf_addr) + 1'b1));
endmodule

// File: tb/sbuf_wr_ptr_mgr_bench.sv
`timescale 1ns/100ps
module sbuf_wr_ptr_mgr_bench;
    localparam int SEC = 2352;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [7:0]  reg_wdata = 8'd0;
    logic [7:0]  reg_rdata;
    logic        sec_start = 1'b0;
    logic        sec_decoded = 1'b0;
    logic [31:0] hdr_in = 32'd0;
    logic [11:0] src_addr;
    logic [7:0]  src_data;
    logic        buf_we;
    logic [15:0] buf_addr;
    logic [7:0]  buf_wdata;
    logic        busy, sec_done, overrun;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;
    int wa_m, pt_m;

    always #2 clk = ~clk;

    sbuf_wr_ptr_mgr u_sbuf_wr_ptr_mgr (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sec_start(sec_start),
        .sec_decoded(sec_decoded), .hdr_in(hdr_in), .src_addr(src_addr),
        .src_data(src_data), .buf_we(buf_we), .buf_addr(buf_addr),
        .buf_wdata(buf_wdata), .busy(busy), .sec_done(sec_done), .overrun(overrun)
    );

    function automatic logic [7:0] src_f(input int k);
        return 8'((k * 7 + 3) ^ (k >> 8));
    endfunction

    // Sector source memory model.
    always_comb src_data = src_f(int'(src_addr));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic host_wr(input logic [1:0] sel, input logic [7:0] val);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = val;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_ptr(input bit p, output int v);
        logic [7:0] lo, hi;
        reg_sel = {p, 1'b0}; #0.2 lo = reg_rdata;
        reg_sel = {p, 1'b1}; #0.2 hi = reg_rdata;
        v = {hi, lo};
    endtask

    task automatic chk_ptrs(input string tag);
        int v;
        rd_ptr(1'b0, v); chk(v == wa_m, {tag, " write address"}, v, wa_m);
        rd_ptr(1'b1, v); chk(v == pt_m, {tag, " sector pointer"}, v, pt_m);
    endtask

    // disturb: 0 none, 1 start pulse mid-sector, 2 host load mid-sector
    task automatic run_sector(input bit dec, input logic [31:0] hdr, input int disturb);
        int n, base, expd;
        n    = dec ? 2052 : SEC;
        base = (pt_m + SEC) & 16'h7FFF;
        pt_m = base;
        wa_m = (wa_m + SEC) & 16'h7FFF;
        @(negedge clk);
        sec_start = 1'b1; sec_decoded = dec; hdr_in = hdr;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (k == 0) begin
                sec_start = 1'b0; sec_decoded = !dec; hdr_in = ~hdr;
            end
            if (dec && k < 4) expd = int'(hdr[8*k +: 8]);
            else              expd = int'(src_f(dec ? k - 4 : k));
            // R4 / R5 / R8: every byte, its address and the write enable
            chk(buf_we && busy && buf_addr == 16'(base + k) && int'(buf_wdata) == expd,
                dec ? "R4 decoded byte" : "R5 raw byte", {buf_we, buf_addr, buf_wdata},
                {1'b1, 16'(base + k), 8'(expd)});
            // R6: done only on the last write
            chk(sec_done == (k == n - 1), "R6 done position", sec_done, k == n - 1);
            if (disturb == 1 && k == 100) sec_start = 1'b1;
            if (disturb == 1 && k == 101) sec_start = 1'b0;
            if (disturb == 2 && k == 500) begin
                reg_wr = 1'b1; reg_sel = 2'd2; reg_wdata = 8'h55;
                pt_m = (pt_m & 16'hFF00) | 8'h55;
            end
            if (disturb == 2 && k == 501) reg_wr = 1'b0;
        end
        @(negedge clk);
        chk(!busy && !buf_we && !sec_done, "R6 idle after sector", {busy, buf_we}, 0);
        chk_ptrs("R3 after sector");
    endtask

    initial begin
        int v;
        int pre_pt [6];
        int pre_wa [6];
        pre_pt = '{16'h0000, 16'h7E00, 16'hFFFF, 16'h7AD0, 16'h8000, 16'h36B0};
        pre_wa = '{16'h1260, 16'hFFFF, 16'h7FFF, 16'h00FF, 16'h4000, 16'h7C00};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset values
        wa_m = 4704; pt_m = 0;
        chk_ptrs("R1 reset");
        chk(!busy && !buf_we && !sec_done && !overrun, "R1 reset flags",
            {busy, buf_we, sec_done, overrun}, 0);

        // R2 byte loads touch only the selected byte
        host_wr(2'd0, 8'hAB); wa_m = 16'h12AB; chk_ptrs("R2 load WA low");
        host_wr(2'd3, 8'hC4); pt_m = 16'hC400; chk_ptrs("R2 load PT high");
        host_wr(2'd1, 8'h07); wa_m = 16'h07AB; chk_ptrs("R2 load WA high");
        host_wr(2'd2, 8'h19); pt_m = 16'hC419; chk_ptrs("R2 load PT low");

        // Sweep of preloads and both forms (R3, R4, R5, R6, R8)
        for (int i = 0; i < 6; i++) begin
            host_wr(2'd0, 8'(pre_wa[i]));      host_wr(2'd1, 8'(pre_wa[i] >> 8));
            host_wr(2'd2, 8'(pre_pt[i]));      host_wr(2'd3, 8'(pre_pt[i] >> 8));
            wa_m = pre_wa[i]; pt_m = pre_pt[i];
            run_sector(i[0], 32'hA1B2C3D4 ^ (i * 32'h01010101), 0);
            run_sector(!i[0], 32'h5E6F7081 + i, 0);
        end
        chk(!overrun, "R7 no overrun without collision", overrun, 0);

        // R7 start while busy is ignored and is flagged
        run_sector(1'b1, 32'h0BADF00D, 1);
        chk(overrun, "R7 overrun set", overrun, 1);
        // R8 host load mid-sector does not move the stream
        run_sector(1'b0, 32'h12345678, 2);
        chk(overrun, "R7 overrun sticky", overrun, 1);
        rd_ptr(1'b1, v);
        chk(v == pt_m, "R8 host load kept", v, pt_m);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule